// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block captures a word of parallel inputs and presents it one bit at a time on a single serial line. It has one true serial output and one inverted serial output. It lives in one system-clock domain. Three control levels arrive from outside the domain and are brought in through two-flop synchronisers: a mode level, a shift clock and a clock-inhibit line. The serial data bit arrives the same way. The parallel word is sampled directly.

While the mode level is low, the stages copy the parallel word on every system cycle. Nothing else has any effect in that state. While the mode level is high, the stages move one place toward the output each time the OR of the shift clock and the inhibit line rises. At each such move the serial bit enters the first stage. At all other times the stages hold their contents. The clock and the inhibit line are treated alike. A rising inhibit edge while the clock is low therefore counts as a shift edge.

Top module: `piso_shift_reg`

## Requirements
- R1: A system clock edge with `rst_n` low clears every stage. After that edge `q_o` reads 0 and `q_n_o` reads 1.
- R2: While the synchronised mode level is 0, every stage takes the value of `par_i` on each system cycle. Shift clock, inhibit and serial input have no effect in that state.
- R3: While the synchronised mode level is 1, a shift happens on a 0-to-1 change of (shift clock OR inhibit). In a shift, stage k+1 takes the old value of stage k and stage 0 takes the serial bit. `q_o` shows stage NSTG-1, which is loaded from `par_i[NSTG-1]`. After a load, `q_o` therefore shows `par_i[7]`, then `par_i[6]`, and so on down to `par_i[0]` on successive shifts.
- R4: A rising inhibit edge while the shift clock is low causes the same shift as a rising clock edge.
- R5: While the mode level is 1 and (clock OR inhibit) does not rise, the stages keep their values. This includes clock toggles while the inhibit line is held high.
- R6: `q_n_o` is always the inverse of `q_o`.
- R7: If a load and an effective clock rise fall in the same system cycle, the load wins. The edge history is still updated, so releasing the load with the clock still high causes no shift.
- R8: A change on the mode, clock, inhibit or serial input acts on the stages at the third rising system-clock edge after it is applied: two synchroniser flops, then the stage register. `par_i` is sampled directly at the edge that loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_mode_i | input | 1 | 1 = shift/hold, 0 = parallel load (asynchronous) |
| shift_clk_i | input | 1 | External shift clock (asynchronous) |
| shift_inh_i | input | 1 | Clock-inhibit line, ORed with the shift clock (asynchronous) |
| ser_i | input | 1 | Serial data entering stage 0 (asynchronous) |
| par_i | input | NSTG | Parallel word; the highest index feeds the stage next to the output |
| q_o | output | 1 | Last stage value |
| q_n_o | output | 1 | Inverse of the last stage value |

## Verification
The bench first loads an alternating word with its top two bits set and clocks it out. This shows whether the bits leave the output in index order, highest first, and whether zeros from the serial input follow them. Separate passes drive shifts from inhibit edges with the clock low, toggle the clock while inhibit is held high, and pull the load low on the same cycle as a clock rise. These passes tell apart a true OR-clock, a plain hold, and load priority with updated edge history. A long pseudo-random sweep of mode, clock, inhibit, serial and parallel values is then compared on every cycle against an arithmetic model of the three-edge latency. This sweep exposes off-by-one-cycle faults and faults in the shift direction.

// File: rtl/pls_pkg.sv
// Package: shared constants and the control bundle for the parallel-load
// serial-out shift register. Assumes nothing beyond a single clock domain.
package pls_pkg;
    localparam int unsigned PLS_STAGES_DEF = 8;
    localparam int unsigned PLS_SYNC_DEPTH = 2;
    localparam int unsigned PLS_CTL_W      = 4;

    // Bit order of the synchronised control word
    typedef struct packed {
        logic mode;
        logic sclk;
        logic inh;
        logic ser;
    } pls_ctl_t;
endpackage

// File: rtl/pls_sync.sv
// Module: multi-bit flop chain that brings asynchronous levels into the
// system clock domain. Each bit is independent; assumes levels are
// slow compared with the system clock.
module pls_sync #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [DEPTH-1:0][W-1:0] pipe;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw asynchronous level
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= '0;
                else        pipe[0] <= d_i;
            end
        end else begin : g_next
            // Pass along the previous flop to settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/pls_edge.sv
// Module: forms the effective shift clock as the OR of the synchronised
// clock and inhibit lines and flags its 0-to-1 change. The history flop
// updates every cycle, including load cycles.
module pls_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic inh_i,
    output logic rise_o,
    output logic eff_q_o
);
    logic eff;

    assign eff = sclk_i | inh_i;

    // Remember last cycle's effective clock level
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q_o <= 1'b0;
        else        eff_q_o <= eff;
    end

    assign rise_o = eff & ~eff_q_o;
endmodule

// File: rtl/pls_stages.sv
// Module: the storage stages. Load is level-driven and has priority; a
// shift moves data toward the top index, serial bit into index 0.
module pls_stages #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_i,
    input  logic         rise_i,
    input  logic         ser_i,
    input  logic [N-1:0] par_i,
    output logic [N-1:0] stg_o
);
    logic [N-1:0] shifted;

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (g == 0) begin : g_head
            assign shifted[0] = ser_i;
        end else begin : g_body
            assign shifted[g] = stg_o[g-1];
        end
    end

    // Load, shift or hold the stages
    always_ff @(posedge clk) begin
        if (!rst_n)       stg_o <= '0;
        else if (!mode_i) stg_o <= par_i;
        else if (rise_i)  stg_o <= shifted;
    end
endmodule

// File: rtl/piso_shift_reg.sv
// Module: top of the parallel-load serial-out shift register. Synchronises
// the external control and serial inputs, detects the effective clock
// edge and drives true and inverted copies of the last stage. Assumes
// par_i is stable whenever the synchronised mode level is low.
module piso_shift_reg #(
    parameter int unsigned NSTG = pls_pkg::PLS_STAGES_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_mode_i,
    input  logic            shift_clk_i,
    input  logic            shift_inh_i,
    input  logic            ser_i,
    input  logic [NSTG-1:0] par_i,
    output logic            q_o,
    output logic            q_n_o
);
    import pls_pkg::*;

    pls_ctl_t     ctl_raw, ctl_s;
    logic         mode_s, sclk_s, inh_s, ser_s;
    logic         rise, eff_q;
    logic [NSTG-1:0] stg;

    assign ctl_raw = '{mode: shift_mode_i, sclk: shift_clk_i,
                       inh: shift_inh_i, ser: ser_i};

    pls_sync #(.W(PLS_CTL_W), .DEPTH(PLS_SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s)
    );

    assign mode_s = ctl_s.mode;
    assign sclk_s = ctl_s.sclk;
    assign inh_s  = ctl_s.inh;
    assign ser_s  = ctl_s.ser;

    pls_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_s), .inh_i(inh_s),
        .rise_o(rise), .eff_q_o(eff_q)
    );

    pls_stages #(.N(NSTG)) u_stages (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_s), .rise_i(rise),
        .ser_i(ser_s), .par_i(par_i), .stg_o(stg)
    );

    assign q_o   = stg[NSTG-1];
    assign q_n_o = ~stg[NSTG-1];
endmodule

// File: rtl/piso_shift_reg_chk.sv
// Module: property checker for piso_shift_reg, attached by bind. It
// rebuilds the edge condition from the synchronised lines and the
// history flop, then relates stage contents across cycles.
module piso_shift_reg_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_s,
    input logic         sclk_s,
    input logic         inh_s,
    input logic         ser_s,
    input logic         eff_q,
    input logic [N-1:0] par_i,
    input logic [N-1:0] stg,
    input logic         q_o,
    input logic         q_n_o
);
    logic edge_seen;
    assign edge_seen = (sclk_s || inh_s) && !eff_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q_o == 1'b0 && q_n_o == 1'b1));

    // R2
    load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_s |=> stg == $past(par_i));

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && edge_seen) |=> stg == {$past(stg[N-2:0]), $past(ser_s)});

    // R5
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && !edge_seen) |=> $stable(stg));

    // R6
    out_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_n_o != q_o);
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.N(NSTG)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .sclk_s(sclk_s),
    .inh_s(inh_s), .ser_s(ser_s), .eff_q(eff_q), .par_i(par_i),
    .stg(stg), .q_o(q_o), .q_n_o(q_n_o)
);

// File: tb/piso_shift_reg_bench.sv
`timescale 1ns/1ps
module piso_shift_reg_bench;
    localparam int unsigned N    = 8;
    localparam real         HALF = 4.0;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode, sclk, inh, ser;
    logic [N-1:0] par;
    logic         q, qn;

    int unsigned  checks = 0;
    int unsigned  errors = 0;
    string        cur_req = "R1";
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    // Arithmetic model: two-deep input pipeline, edge history, stages
    logic [3:0]   m_s1, m_s2;
    logic         m_prev;
    logic [N-1:0] m_reg;

    always #(HALF) clk = ~clk;

    piso_shift_reg #(.NSTG(N)) u_piso_shift_reg (
        .clk(clk), .rst_n(rst_n), .shift_mode_i(mode), .shift_clk_i(sclk),
        .shift_inh_i(inh), .ser_i(ser), .par_i(par), .q_o(q), .q_n_o(qn)
    );

    // R8 latency model: {mode,sclk,inh,ser} pass two flops before use
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= 1'b0; m_reg <= '0;
        end else begin
            m_s1   <= {mode, sclk, inh, ser};
            m_s2   <= m_s1;
            m_prev <= m_s2[2] | m_s2[1];
            if (!m_s2[3])
                m_reg <= par;
            else if ((m_s2[2] | m_s2[1]) && !m_prev)
                m_reg <= {m_reg[N-2:0], m_s2[0]};
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare both outputs against the model, then apply new inputs
    task automatic step(input logic m, input logic c, input logic h,
                        input logic s, input logic [N-1:0] p);
        @(negedge clk);
        check_bit(cur_req, q, m_reg[N-1]);
        check_bit("R6", qn, ~q);
        mode = m; sclk = c; inh = h; ser = s; par = p;
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) step(mode, sclk, inh, ser, par);
    endtask

    initial begin
        #(HALF * 2.0 * 150000);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] pat;
        rst_n = 1'b0; mode = 1'b1; sclk = 1'b0; inh = 1'b0; ser = 1'b0; par = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1", q, 1'b0);
        check_bit("R1", qn, 1'b1);
        rst_n = 1'b1;
        hold(3);

        // R2 / R3: load the pattern, then clock it out highest index first
        cur_req = "R2";
        pat = 8'hD5;
        step(1'b0, 1'b1, 1'b0, 1'b1, pat);
        for (int i = 0; i < 3; i++) step(1'b0, ~sclk, inh, ~ser, pat);
        step(1'b1, 1'b0, 1'b0, 1'b0, pat);
        hold(4);
        check_bit("R2", q, pat[N-1]);
        cur_req = "R3";
        for (int k = 1; k <= N + 2; k++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, pat);
            hold(3);
            step(1'b1, 1'b0, 1'b0, 1'b0, pat);
            hold(3);
            check_bit("R3", q, (k < N) ? pat[N-1-k] : 1'b0);
        end

        // R4: inhibit edges with the clock low shift ones in
        cur_req = "R4";
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0, 1'b1, 1'b1, pat);
            hold(4);
            step(1'b1, 1'b0, 1'b0, 1'b1, pat);
            hold(4);
        end

        // R5: inhibit held high, clock toggles, nothing moves
        cur_req = "R5";
        step(1'b1, 1'b0, 1'b1, 1'b0, pat);
        hold(4);
        for (int k = 0; k < 6; k++) begin
            step(1'b1, ~sclk, 1'b1, ~ser, pat);
            hold(3);
        end
        step(1'b1, 1'b0, 1'b0, 1'b0, pat);
        hold(4);

        // R7: load asserted on the same cycle as a clock rise
        cur_req = "R7";
        pat = 8'h5A;
        step(1'b0, 1'b1, 1'b0, 1'b0, pat);
        hold(4);
        step(1'b1, 1'b1, 1'b0, 1'b0, pat);
        hold(5);
        check_bit("R7", q, pat[N-1]);
        step(1'b1, 1'b0, 1'b0, 1'b0, pat);
        hold(4);

        // R3 / R8: long pseudo-random sweep compared every cycle
        cur_req = "R3";
        for (int i = 0; i < 6000; i++) begin
            logic m, c, h;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            m = (lfsr[4:0] == 5'd0) ? ~mode : mode;
            c = (lfsr[7:5] == 3'd0) ? ~sclk : sclk;
            h = (lfsr[11:8] == 4'd0) ? ~inh : inh;
            step(m, c, h, lfsr[13], lfsr[23:16]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule